// File: doc/BRIEF.md
# GPIB Interface Register File

This block is the byte-wide register window that a host processor uses to run a GPIB talker, listener and controller. A 3-bit address selects one of eight write registers and one of eight read registers. The write side holds the outgoing command or data byte, two interrupt masks, the serial poll mode byte, the address mode byte, the address slots, the end-of-string byte and a single auxiliary port. The read side returns the received byte, two event status bytes, the serial poll byte, a controller state summary, the parallel poll response and the two address slots.

The auxiliary port does two jobs. When its upper three bits are zero, the lower five bits name an immediate command: take or release bus control, pulse or hold the interface clear and remote enable lines, mark the next byte as the last one, run a parallel poll, reset the chip, or bring it back online. Other upper-bit patterns load one of five hidden 5-bit configuration fields. A separate handshake engine (not part of this block) consumes outgoing bytes and reports received bytes, acknowledgements and service requests. Status flags are latched here and combined with the masks into one level interrupt.

Top module: `gpib_regfile`

## Requirements
- R1: After reset, status 1 reads 0x02 (only data-out-ready set), status 2 reads 0x00, the state summary reads 0x00, and `atn_o`, `ifc_o`, `ren_o`, `online_o`, `irq` and `tx_strobe` are all 0.
- R2: Write offsets are 0 data out, 1 mask 1, 2 mask 2, 3 serial poll mode, 4 address mode, 5 auxiliary, 6 address, 7 end-of-string. The serial poll byte reads back at read offset 3. The address mode and end-of-string bytes drive `mode_o` and `eos_o`.
- R3: The auxiliary immediate codes (octal) have these effects: 021 sets `atn_o` and 020 clears it; 036 sets `ifc_o` and 026 clears it; 037 sets `ren_o` and 027 clears it; 035 gives a one-cycle `pp_exec` pulse. Each line holds its level until the matching command.
- R4: An auxiliary write whose top three bits are 001, 011, 100, 101 or 110 loads its low five bits into hidden field 0 (counter), 1 (parallel poll), 2 (aux A), 3 (aux B) or 4 (aux E). Field i sits at `hid_cfg[5*i+4:5*i]`. Top bits 010 or 111 change nothing.
- R5: An address write uses bit 7 to pick slot 1 (1) or slot 0 (0), bit 6 as talker disable, bit 5 as listener disable and bits 4:0 as the address. Read offsets 6 and 7 return slot 0 and slot 1 as {0, talker-disable, listener-disable, address}. The other slot is left unchanged.
- R6: A data-out write while online gives a one-cycle `tx_strobe` on the next cycle, with `tx_byte` and with `tx_cmd` set to `atn_o` at the time of the write, and it clears status 1 bit 1. `eng_tx_ack` sets status 1 bit 1 again. If the acknowledged byte was a command, it also sets status 2 bit 3 (command output complete).
- R7: Auxiliary code 006 sets `tx_eoi` on the next data-out byte only.
- R8: `eng_rx_valid` while online latches `eng_rx_byte` into read offset 0 and sets status 1 bit 0. It also sets status 1 bit 4 if `eng_rx_end` is high. Reading offset 0 clears bit 0.
- R9: Reading status 1 clears bit 4. Reading status 2 clears bits 3 and 6. Bit 6 is set only on a rising edge of `eng_srq`, so each request is reported once. An event arriving in the same cycle as the clearing read stays set.
- R10: `irq` is high exactly when some status 1 bit is set under mask 1 or some status 2 bit is set under mask 2.
- R11: Auxiliary code 002 returns every register, hidden field and output to its reset value and leaves the chip offline. While offline, engine inputs are ignored and data-out writes are dropped. Code 000 brings the chip online.
- R12: Read offset 5 returns `pp_resp`. Read offset 4 returns {0000, ren, ifc, atn, online}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears read-sensitive flags) |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Masked status level |
| tx_strobe | output | 1 | Outgoing byte valid pulse |
| tx_byte | output | 8 | Outgoing byte |
| tx_cmd | output | 1 | Outgoing byte is a command |
| tx_eoi | output | 1 | Outgoing byte is the last of a message |
| eng_tx_ack | input | 1 | Engine finished sending the outgoing byte |
| eng_rx_valid | input | 1 | Engine received a byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_rx_end | input | 1 | Received byte carried END |
| eng_srq | input | 1 | Service request line level |
| pp_resp | input | 8 | Parallel poll response byte |
| pp_exec | output | 1 | Parallel poll start pulse |
| atn_o | output | 1 | Controller active (attention asserted) |
| ifc_o | output | 1 | Interface clear level |
| ren_o | output | 1 | Remote enable level |
| online_o | output | 1 | Chip online |
| mode_o | output | 8 | Address mode byte |
| eos_o | output | 8 | End-of-string byte |
| hid_cfg | output | 25 | Five hidden 5-bit configuration fields |

## Verification
The embedded properties check cycle-local relations on every cycle: take-control always raises attention on the next cycle; interface clear rises only after its set command; strobes happen only while online; reserved hidden groups leave the fields stable; and the clearing rules for data-in, data-out and service request bits hold. What only the directed scenarios can show is the end-to-end meaning: byte values read at each offset, the one-shot nature of the EOI mark, the command-versus-data split of acknowledgements, a service request surviving a coinciding clear read, interrupt masking, and the full return to reset state after a chip reset.

// File: rtl/gpib_rf_pkg.sv
package gpib_rf_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int FIELD_W = 5;
  localparam int NUM_HID = 5;
  localparam int HID_W   = NUM_HID * FIELD_W;

  // register offsets (shared by read and write sides)
  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_ST1  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_ST2  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_SPOL = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_MODE = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_AUX  = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_ADR  = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_EOS  = 3'd7;
  localparam logic [ADDR_W-1:0] OFS_MSK1 = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_MSK2 = 3'd2;

  // immediate auxiliary codes (low five bits, group 000)
  localparam logic [FIELD_W-1:0] IMM_ONLINE = 5'o00;
  localparam logic [FIELD_W-1:0] IMM_RESET  = 5'o02;
  localparam logic [FIELD_W-1:0] IMM_LAST   = 5'o06;
  localparam logic [FIELD_W-1:0] IMM_TAKE   = 5'o21;
  localparam logic [FIELD_W-1:0] IMM_STBY   = 5'o20;
  localparam logic [FIELD_W-1:0] IMM_PPOLL  = 5'o35;
  localparam logic [FIELD_W-1:0] IMM_IFC_ON = 5'o36;
  localparam logic [FIELD_W-1:0] IMM_IFC_OF = 5'o26;
  localparam logic [FIELD_W-1:0] IMM_REN_ON = 5'o37;
  localparam logic [FIELD_W-1:0] IMM_REN_OF = 5'o27;

  // status bit positions
  localparam int S1_DIN  = 0;
  localparam int S1_DOUT = 1;
  localparam int S1_END  = 4;
  localparam int S2_CMD  = 3;
  localparam int S2_SRQ  = 6;

  typedef struct packed {
    logic online, reset, last, take, stby, ppoll, ifc_on, ifc_of, ren_on, ren_of;
  } imm_cmd_t;
endpackage

// File: rtl/gpib_aux_decode.sv
module gpib_aux_decode
  import gpib_rf_pkg::*;
(
  input  logic               wr,
  input  logic [BYTE_W-1:0]  aux_byte,
  output imm_cmd_t           imm,
  output logic [NUM_HID-1:0] hid_ld,
  output logic [FIELD_W-1:0] field
);
  assign field = aux_byte[FIELD_W-1:0];

  always_comb begin
    imm    = '0;
    hid_ld = '0;
    if (wr) begin
      case (aux_byte[BYTE_W-1:FIELD_W])
        3'b000: begin
          case (field)
            IMM_ONLINE: imm.online = 1'b1;
            IMM_RESET:  imm.reset  = 1'b1;
            IMM_LAST:   imm.last   = 1'b1;
            IMM_TAKE:   imm.take   = 1'b1;
            IMM_STBY:   imm.stby   = 1'b1;
            IMM_PPOLL:  imm.ppoll  = 1'b1;
            IMM_IFC_ON: imm.ifc_on = 1'b1;
            IMM_IFC_OF: imm.ifc_of = 1'b1;
            IMM_REN_ON: imm.ren_on = 1'b1;
            IMM_REN_OF: imm.ren_of = 1'b1;
            default: ;
          endcase
        end
        3'b001:  hid_ld[0] = 1'b1;
        3'b011:  hid_ld[1] = 1'b1;
        3'b100:  hid_ld[2] = 1'b1;
        3'b101:  hid_ld[3] = 1'b1;
        3'b110:  hid_ld[4] = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpib_status.sv
module gpib_status
  import gpib_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ev_rx,
  input  logic              ev_rx_end,
  input  logic              ev_ack,
  input  logic              ack_cmd,
  input  logic              ev_srq,
  input  logic              do_write,
  input  logic              rd_din,
  input  logic              rd_st1,
  input  logic              rd_st2,
  input  logic [BYTE_W-1:0] mask1,
  input  logic [BYTE_W-1:0] mask2,
  output logic [BYTE_W-1:0] st1,
  output logic [BYTE_W-1:0] st2,
  output logic              irq
);
  logic din_q, dout_q, end_q, cmd_q, srq_q;
  logic din_nx, dout_nx, end_nx, cmd_nx, srq_nx;

  always_comb begin
    if (clr) begin
      din_nx = 1'b0; dout_nx = 1'b1; end_nx = 1'b0; cmd_nx = 1'b0; srq_nx = 1'b0;
    end else begin
      din_nx  = ev_rx | (din_q & ~rd_din);
      dout_nx = do_write ? 1'b0 : (ev_ack | dout_q);
      end_nx  = (ev_rx & ev_rx_end) | (end_q & ~rd_st1);
      cmd_nx  = (ev_ack & ack_cmd) | (cmd_q & ~rd_st2);
      srq_nx  = ev_srq | (srq_q & ~rd_st2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q <= 1'b0; dout_q <= 1'b1; end_q <= 1'b0; cmd_q <= 1'b0; srq_q <= 1'b0;
    end else begin
      din_q <= din_nx; dout_q <= dout_nx; end_q <= end_nx; cmd_q <= cmd_nx; srq_q <= srq_nx;
    end
  end

  always_comb begin
    st1 = '0;
    st2 = '0;
    st1[S1_DIN]  = din_q;
    st1[S1_DOUT] = dout_q;
    st1[S1_END]  = end_q;
    st2[S2_CMD]  = cmd_q;
    st2[S2_SRQ]  = srq_q;
  end

  assign irq = |(st1 & mask1) | |(st2 & mask2);

  // R9: a clearing read with no new request leaves the request bit clear
  a_r9_srq_single: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_st2 && !ev_srq && !clr) |=> !srq_q);
  // R8: reading data in clears data-in-ready unless a new byte lands
  a_r8_din_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_din && !ev_rx && !clr) |=> !din_q);
  // R6: a data-out write leaves data-out-ready low on the next cycle
  a_r6_dout_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (do_write && !clr) |=> !dout_q);
endmodule

// File: rtl/gpib_regfile.sv
module gpib_regfile
  import gpib_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_cmd,
  output logic              tx_eoi,
  input  logic              eng_tx_ack,
  input  logic              eng_rx_valid,
  input  logic [BYTE_W-1:0] eng_rx_byte,
  input  logic              eng_rx_end,
  input  logic              eng_srq,
  input  logic [BYTE_W-1:0] pp_resp,
  output logic              pp_exec,
  output logic              atn_o,
  output logic              ifc_o,
  output logic              ren_o,
  output logic              online_o,
  output logic [BYTE_W-1:0] mode_o,
  output logic [BYTE_W-1:0] eos_o,
  output logic [HID_W-1:0]  hid_cfg
);
  localparam int SLOT_W = BYTE_W - 1;

  // reset: asserted asynchronously, released on a clock edge
  logic rs_a, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a <= 1'b0; rs_n <= 1'b0;
    end else begin
      rs_a <= 1'b1; rs_n <= rs_a;
    end
  end

  // write and read strobes
  logic wr_dout, wr_m1, wr_m2, wr_spol, wr_mode, wr_aux, wr_adr, wr_eos;
  logic rd_din, rd_st1, rd_st2;
  assign wr_dout = wr_en && addr == OFS_DATA;
  assign wr_m1   = wr_en && addr == OFS_MSK1;
  assign wr_m2   = wr_en && addr == OFS_MSK2;
  assign wr_spol = wr_en && addr == OFS_SPOL;
  assign wr_mode = wr_en && addr == OFS_MODE;
  assign wr_aux  = wr_en && addr == OFS_AUX;
  assign wr_adr  = wr_en && addr == OFS_ADR;
  assign wr_eos  = wr_en && addr == OFS_EOS;
  assign rd_din  = rd_en && addr == OFS_DATA;
  assign rd_st1  = rd_en && addr == OFS_ST1;
  assign rd_st2  = rd_en && addr == OFS_ST2;

  imm_cmd_t           imm;
  logic [NUM_HID-1:0] hid_ld;
  logic [FIELD_W-1:0] aux_field;
  logic               clr;

  gpib_aux_decode u_dec (
    .wr(wr_aux), .aux_byte(wdata), .imm(imm), .hid_ld(hid_ld), .field(aux_field)
  );
  assign clr = imm.reset;

  // hidden configuration fields
  for (genvar g = 0; g < NUM_HID; g++) begin : g_hid
    logic [FIELD_W-1:0] q, nx;
    always_comb nx = clr ? '0 : (hid_ld[g] ? aux_field : q);
    always_ff @(posedge clk or negedge rs_n) begin
      if (!rs_n) q <= '0;
      else       q <= nx;
    end
    assign hid_cfg[g*FIELD_W +: FIELD_W] = q;
  end

  // visible registers and control state
  logic [BYTE_W-1:0] msk1_q, msk2_q, spol_q, mode_q, eos_q, din_q;
  logic [SLOT_W-1:0] slot0_q, slot1_q;
  logic              atn_q, ifc_q, ren_q, onl_q, last_q, srqd_q, pp_q;
  logic              txs_q, txc_q, txe_q;
  logic [BYTE_W-1:0] txb_q;

  logic [BYTE_W-1:0] msk1_nx, msk2_nx, spol_nx, mode_nx, eos_nx, din_nx;
  logic [SLOT_W-1:0] slot0_nx, slot1_nx;
  logic              atn_nx, ifc_nx, ren_nx, onl_nx, last_nx, pp_nx;
  logic              txs_nx, txc_nx, txe_nx;
  logic [BYTE_W-1:0] txb_nx;

  logic ev_rx, ev_ack, ev_srq, do_write;
  assign ev_rx    = onl_q & eng_rx_valid;
  assign ev_ack   = onl_q & eng_tx_ack;
  assign ev_srq   = onl_q & eng_srq & ~srqd_q;
  assign do_write = onl_q & wr_dout;

  always_comb begin
    msk1_nx  = wr_m1   ? wdata : msk1_q;
    msk2_nx  = wr_m2   ? wdata : msk2_q;
    spol_nx  = wr_spol ? wdata : spol_q;
    mode_nx  = wr_mode ? wdata : mode_q;
    eos_nx   = wr_eos  ? wdata : eos_q;
    slot0_nx = (wr_adr && !wdata[BYTE_W-1]) ? wdata[SLOT_W-1:0] : slot0_q;
    slot1_nx = (wr_adr &&  wdata[BYTE_W-1]) ? wdata[SLOT_W-1:0] : slot1_q;
    din_nx   = ev_rx ? eng_rx_byte : din_q;
    atn_nx   = imm.take | (atn_q & ~imm.stby);
    ifc_nx   = imm.ifc_on | (ifc_q & ~imm.ifc_of);
    ren_nx   = imm.ren_on | (ren_q & ~imm.ren_of);
    onl_nx   = imm.online | onl_q;
    last_nx  = imm.last | (last_q & ~do_write);
    pp_nx    = imm.ppoll;
    txs_nx   = do_write;
    txb_nx   = do_write ? wdata  : txb_q;
    txc_nx   = do_write ? atn_q  : txc_q;
    txe_nx   = do_write ? last_q : txe_q;
    if (clr) begin
      msk1_nx = '0; msk2_nx = '0; spol_nx = '0; mode_nx = '0; eos_nx = '0; din_nx = '0;
      slot0_nx = '0; slot1_nx = '0;
      atn_nx = 1'b0; ifc_nx = 1'b0; ren_nx = 1'b0; onl_nx = 1'b0; last_nx = 1'b0;
      pp_nx = 1'b0; txs_nx = 1'b0; txb_nx = '0; txc_nx = 1'b0; txe_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      msk1_q <= '0; msk2_q <= '0; spol_q <= '0; mode_q <= '0; eos_q <= '0; din_q <= '0;
      slot0_q <= '0; slot1_q <= '0;
      atn_q <= 1'b0; ifc_q <= 1'b0; ren_q <= 1'b0; onl_q <= 1'b0; last_q <= 1'b0;
      srqd_q <= 1'b0; pp_q <= 1'b0;
      txs_q <= 1'b0; txb_q <= '0; txc_q <= 1'b0; txe_q <= 1'b0;
    end else begin
      msk1_q <= msk1_nx; msk2_q <= msk2_nx; spol_q <= spol_nx; mode_q <= mode_nx;
      eos_q <= eos_nx; din_q <= din_nx; slot0_q <= slot0_nx; slot1_q <= slot1_nx;
      atn_q <= atn_nx; ifc_q <= ifc_nx; ren_q <= ren_nx; onl_q <= onl_nx; last_q <= last_nx;
      srqd_q <= eng_srq; pp_q <= pp_nx;
      txs_q <= txs_nx; txb_q <= txb_nx; txc_q <= txc_nx; txe_q <= txe_nx;
    end
  end

  logic [BYTE_W-1:0] st1, st2;

  gpib_status u_stat (
    .clk(clk), .rst_n(rs_n), .clr(clr),
    .ev_rx(ev_rx), .ev_rx_end(eng_rx_end), .ev_ack(ev_ack), .ack_cmd(txc_q),
    .ev_srq(ev_srq), .do_write(do_write),
    .rd_din(rd_din), .rd_st1(rd_st1), .rd_st2(rd_st2),
    .mask1(msk1_q), .mask2(msk2_q), .st1(st1), .st2(st2), .irq(irq)
  );

  always_comb begin
    case (addr)
      OFS_DATA: rdata = din_q;
      OFS_ST1:  rdata = st1;
      OFS_ST2:  rdata = st2;
      OFS_SPOL: rdata = spol_q;
      OFS_MODE: rdata = {4'b0000, ren_q, ifc_q, atn_q, onl_q};
      OFS_AUX:  rdata = pp_resp;
      OFS_ADR:  rdata = {1'b0, slot0_q};
      default:  rdata = {1'b0, slot1_q};
    endcase
  end

  assign tx_strobe = txs_q;
  assign tx_byte   = txb_q;
  assign tx_cmd    = txc_q;
  assign tx_eoi    = txe_q;
  assign pp_exec   = pp_q;
  assign atn_o     = atn_q;
  assign ifc_o     = ifc_q;
  assign ren_o     = ren_q;
  assign online_o  = onl_q;
  assign mode_o    = mode_q;
  assign eos_o     = eos_q;

  // R3: take-control raises attention on the next cycle
  a_r3_take_sets_atn: assert property (@(posedge clk) disable iff (!rs_n)
    imm.take |=> atn_o);
  // R3: interface clear only rises after its set command
  a_r3_ifc_rise: assert property (@(posedge clk) disable iff (!rs_n)
    $rose(ifc_o) |-> $past(imm.ifc_on));
  // R11: no outgoing strobe unless the chip was online at the write
  a_r11_strobe_online: assert property (@(posedge clk) disable iff (!rs_n)
    tx_strobe |-> $past(online_o));
  // R4: reserved group 010 leaves every hidden field unchanged
  a_r4_reserved_group: assert property (@(posedge clk) disable iff (!rs_n)
    (wr_aux && wdata[BYTE_W-1:FIELD_W] == 3'b010) |=> $stable(hid_cfg));
endmodule

// File: tb/gpib_regfile_bench.sv
`timescale 1ns/1ps
module gpib_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n, wr_en, rd_en;
  logic [2:0]  addr;
  logic [7:0]  wdata, rdata, tx_byte, eng_rx_byte, pp_resp, mode_o, eos_o;
  logic        irq, tx_strobe, tx_cmd, tx_eoi, eng_tx_ack, eng_rx_valid, eng_rx_end, eng_srq;
  logic        pp_exec, atn_o, ifc_o, ren_o, online_o;
  logic [24:0] hid_cfg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpib_regfile u_gpib_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .tx_strobe(tx_strobe), .tx_byte(tx_byte), .tx_cmd(tx_cmd),
    .tx_eoi(tx_eoi), .eng_tx_ack(eng_tx_ack), .eng_rx_valid(eng_rx_valid),
    .eng_rx_byte(eng_rx_byte), .eng_rx_end(eng_rx_end), .eng_srq(eng_srq),
    .pp_resp(pp_resp), .pp_exec(pp_exec), .atn_o(atn_o), .ifc_o(ifc_o), .ren_o(ren_o),
    .online_o(online_o), .mode_o(mode_o), .eos_o(eos_o), .hid_cfg(hid_cfg)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic rx(input logic [7:0] b, input logic e);
    eng_rx_byte = b; eng_rx_end = e; eng_rx_valid = 1'b1;
    tick();
    eng_rx_valid = 1'b0; eng_rx_end = 1'b0;
  endtask

  task automatic ack();
    eng_tx_ack = 1'b1;
    tick();
    eng_tx_ack = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(3'd1, v); chk("R1 status1", v, 8'h02);
    rd(3'd2, v); chk("R1 status2", v, 8'h00);
    rd(3'd4, v); chk("R1 state", v, 8'h00);
    chk("R1 lines", {atn_o, ifc_o, ren_o, online_o, irq, tx_strobe}, 0);
  endtask

  task automatic t_offsets();
    logic [7:0] v;
    wr(3'd5, 8'o000);
    rd(3'd4, v); chk("R11 online", v, 8'h01);
    wr(3'd3, 8'hA5); rd(3'd3, v); chk("R2 serial poll readback", v, 8'hA5);
    wr(3'd4, 8'h31); chk("R2 mode_o", mode_o, 8'h31);
    wr(3'd7, 8'h0A); chk("R2 eos_o", eos_o, 8'h0A);
  endtask

  task automatic t_immediate();
    logic [7:0] v;
    wr(3'd5, 8'o021); chk("R3 atn set", atn_o, 1);
    rd(3'd4, v); chk("R12 state", v, 8'h03);
    wr(3'd5, 8'o036); chk("R3 ifc set", ifc_o, 1);
    tick(); chk("R3 ifc held", ifc_o, 1);
    wr(3'd5, 8'o026); chk("R3 ifc clear", ifc_o, 0);
    wr(3'd5, 8'o037); chk("R3 ren set", ren_o, 1);
    wr(3'd5, 8'o027); chk("R3 ren clear", ren_o, 0);
    wr(3'd5, 8'o020); chk("R3 atn clear", atn_o, 0);
    wr(3'd5, 8'o035); chk("R3 pp pulse", pp_exec, 1);
    tick(); chk("R3 pp pulse end", pp_exec, 0);
  endtask

  task automatic t_hidden();
    wr(3'd5, 8'b001_00101); wr(3'd5, 8'b011_10000); wr(3'd5, 8'b100_00011);
    wr(3'd5, 8'b101_00111); wr(3'd5, 8'b110_01001);
    chk("R4 hidden loads", hid_cfg, {5'd9, 5'd7, 5'd3, 5'd16, 5'd5});
    wr(3'd5, 8'b010_11111); wr(3'd5, 8'b111_11111);
    chk("R4 reserved groups", hid_cfg, {5'd9, 5'd7, 5'd3, 5'd16, 5'd5});
  endtask

  task automatic t_address();
    logic [7:0] v;
    wr(3'd6, 8'h07); rd(3'd6, v); chk("R5 slot0", v, 8'h07);
    wr(3'd6, 8'hFF); rd(3'd7, v); chk("R5 slot1", v, 8'h7F);
    rd(3'd6, v); chk("R5 slot0 kept", v, 8'h07);
  endtask

  task automatic t_dataout();
    logic [7:0] v;
    wr(3'd5, 8'o021);
    wr(3'd0, 8'h3F);
    chk("R6 strobe", {tx_strobe, tx_cmd, tx_eoi}, 3'b110);
    chk("R6 byte", tx_byte, 8'h3F);
    rd(3'd1, v); chk("R6 dout ready cleared", v, 8'h00);
    chk("R6 strobe one cycle", tx_strobe, 0);
    ack();
    rd(3'd1, v); chk("R6 dout ready after ack", v, 8'h02);
    rd(3'd2, v); chk("R6 command complete", v, 8'h08);
    rd(3'd2, v); chk("R9 status2 cleared", v, 8'h00);
    wr(3'd5, 8'o020);
    wr(3'd0, 8'h55); chk("R6 data byte not cmd", {tx_strobe, tx_cmd}, 2'b10);
    ack();
    rd(3'd2, v); chk("R6 no cmd flag for data", v, 8'h00);
  endtask

  task automatic t_eoi();
    wr(3'd5, 8'o006);
    wr(3'd0, 8'h41); chk("R7 eoi marked", {tx_strobe, tx_eoi}, 2'b11);
    ack();
    wr(3'd0, 8'h42); chk("R7 eoi only once", {tx_strobe, tx_eoi}, 2'b10);
    ack();
  endtask

  task automatic t_receive();
    logic [7:0] v;
    rx(8'h5A, 1'b0);
    rd(3'd1, v); chk("R8 din ready", v, 8'h03);
    rd(3'd0, v); chk("R8 din byte", v, 8'h5A);
    rd(3'd1, v); chk("R8 din ready cleared", v, 8'h02);
    rx(8'h0A, 1'b1);
    rd(3'd1, v); chk("R8 end flag", v, 8'h13);
    rd(3'd1, v); chk("R9 end cleared by read", v, 8'h03);
    rd(3'd0, v); chk("R8 second byte", v, 8'h0A);
  endtask

  task automatic t_srq();
    logic [7:0] v;
    eng_srq = 1'b1; tick();
    rd(3'd2, v); chk("R9 srq reported", v, 8'h40);
    rd(3'd2, v); chk("R9 srq once", v, 8'h00);
    eng_srq = 1'b0; tick();
    rd_en = 1'b1; addr = 3'd2; eng_srq = 1'b1;
    #1 v = rdata; tick(); rd_en = 1'b0;
    chk("R9 read before edge", v, 8'h00);
    rd(3'd2, v); chk("R9 srq survives clear", v, 8'h40);
    eng_srq = 1'b0; tick();
  endtask

  task automatic t_irq();
    logic [7:0] v;
    chk("R10 no mask no irq", irq, 0);
    wr(3'd1, 8'h01);
    rx(8'h33, 1'b0); chk("R10 irq on din", irq, 1);
    rd(3'd0, v); chk("R10 irq drops", irq, 0);
    wr(3'd2, 8'h40);
    eng_srq = 1'b1; tick(); chk("R10 irq on srq", irq, 1);
    rd(3'd2, v); chk("R10 irq drops srq", irq, 0);
    eng_srq = 1'b0; wr(3'd1, 8'h00); wr(3'd2, 8'h00);
  endtask

  task automatic t_passthru();
    logic [7:0] v;
    pp_resp = 8'hC3;
    rd(3'd5, v); chk("R12 pass-through", v, 8'hC3);
  endtask

  task automatic t_chip_reset();
    logic [7:0] v;
    wr(3'd5, 8'o021); wr(3'd5, 8'o037);
    wr(3'd5, 8'o002);
    rd(3'd4, v); chk("R11 offline state", v, 8'h00);
    rd(3'd3, v); chk("R11 spoll cleared", v, 8'h00);
    chk("R11 mode/hidden cleared", {mode_o, eos_o, hid_cfg}, 0);
    rd(3'd6, v); chk("R11 slot cleared", v, 8'h00);
    rx(8'h99, 1'b1);
    rd(3'd1, v); chk("R11 rx ignored offline", v, 8'h02);
    wr(3'd0, 8'h77); chk("R11 no strobe offline", tx_strobe, 0);
    wr(3'd5, 8'o000);
    rd(3'd4, v); chk("R11 back online", v, 8'h01);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    eng_tx_ack = 1'b0; eng_rx_valid = 1'b0; eng_rx_byte = '0; eng_rx_end = 1'b0;
    eng_srq = 1'b0; pp_resp = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_offsets();
    t_immediate();
    t_hidden();
    t_address();
    t_dataout();
    t_eoi();
    t_receive();
    t_srq();
    t_irq();
    t_passthru();
    t_chip_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule